// File: doc/BRIEF.md
# Memory-Card Host Event Router

This block gathers the event flags of a memory-card host controller in one pending word. It combines them with a software mask and drives three outputs: one level-sensitive interrupt line toward the CPU, and two DMA request lines, one for receive and one for transmit. The data and command engines raise events through set strobes. Each engine lowers its own events through clear strobes, because the bus cannot write the pending word. A DMA-enable input, taken from the command/data control word, decides where the FIFO service requests go. With DMA off they reach the interrupt line like any other event. With DMA on they are kept away from the CPU and drive the DMA request lines instead.

The block also decodes writes to the clock start/stop control register. A small state machine has two states. `CLK_HALTED` is the reset state and `CLK_RUNNING` is the other. The transitions are:

- HALTED to RUNNING on a start-only write.
- RUNNING to HALTED on any write carrying the stop bit.
- HALTED stays HALTED on a stop write.
- RUNNING stays RUNNING on a start write.
- Either state holds on a write that carries neither bit, or when no write takes place.

A start write clears the clock-off pending flag. A stop write sets that flag and emits a one-cycle transfer-abort pulse for the data engine.

Top module: `mmc_evt_router`

## Requirements
- R1: After reset the pending word, the mask, the interrupt, both DMA requests, the clock-running status and the abort pulse are all zero.
- R2: A mask write stores the low 13 bits of the write data and discards the upper bits. The stored mask reads back on the next cycle. A set mask bit suppresses the matching event from the interrupt.
- R3: Pending bits are sticky. A set strobe raises a bit on the next cycle, and the bit stays until its clear strobe lowers it. When set and clear of the same bit coincide, the set wins.
- R4: The interrupt is high exactly when some pending bit is set whose effective mask bit is clear. It follows a mask change on the cycle after the write.
- R5: While DMA is enabled, receive FIFO request (bit 5) and transmit FIFO request (bit 6) are treated as masked for the interrupt. Other unmasked events still raise it.
- R6: While DMA is enabled, the receive DMA request equals pending bit 5 and the transmit DMA request equals pending bit 6. While DMA is disabled, both requests are low.
- R7: A clock-control write with bit 1 set and bit 0 clear makes the clock-running status high and clears the clock-off pending bit (bit 4).
- R8: A clock-control write with bit 0 set makes the clock-running status low and sets pending bit 4. It also produces a transfer-abort pulse of exactly one cycle on the next cycle.
- R9: When both control bits are set in one write, stop takes precedence. A control write with neither bit set changes neither the clock status nor pending bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | BUS_W | Mask write data; low EVT_N bits kept |
| mask_q | output | EVT_N | Mask register read port |
| pend_q | output | EVT_N | Pending-request word read port |
| evt_set | input | EVT_N | Per-event set strobes from the engines |
| evt_clr | input | EVT_N | Per-event clear strobes from the owning engines |
| dma_en | input | 1 | DMA-enable bit of the command/data control word |
| clkctl_wr_en | input | 1 | Clock control register write strobe |
| clkctl_wr_data | input | 2 | bit 0 stop, bit 1 start |
| irq | output | 1 | Level-sensitive interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| clk_running | output | 1 | Clock-enabled status |
| xfer_abort | output | 1 | One-cycle abort pulse after a stop write |

## Verification
The hardest case to reach from the ports is a FIFO request that is pending at the moment DMA is switched on while another, unrelated event is also pending. Only then does the interrupt have to stay high for one cause while the FIFO cause is diverted to a DMA line. The directed DMA scenario builds this case in stages. It first raises the receive request with DMA off, then turns DMA on, then adds the transmit request, then adds a data-done event. Both the interrupt and the request lines are checked after each stage. Coincident set/clear strobes and a control write carrying both start and stop are driven in single cycles to exercise the precedence rules.

// File: rtl/mmc_evt_pkg.sv
package mmc_evt_pkg;

    // Event bit positions in the pending word (decoded by software and engines)
    localparam int EVT_COUNT     = 13;
    localparam int EV_DATA_DONE  = 0;
    localparam int EV_PROG_DONE  = 1;
    localparam int EV_CMD_END    = 2;
    localparam int EV_STOP_CMD   = 3;
    localparam int EV_CLK_OFF    = 4;
    localparam int EV_RX_REQ     = 5;
    localparam int EV_TX_REQ     = 6;
    localparam int EV_SDIO_ACK   = 12;

    // Clock control write fields
    localparam int CTL_W         = 2;
    localparam int CTL_STOP_BIT  = 0;
    localparam int CTL_START_BIT = 1;

    typedef enum logic [0:0] {
        CLK_HALTED  = 1'b0,
        CLK_RUNNING = 1'b1
    } clk_state_e;

    typedef struct packed {
        logic stop;
        logic start;
    } clk_cmd_t;

endpackage

// File: rtl/mmc_evt_mask_reg.sv
module mmc_evt_mask_reg #(
    parameter int BUS_W = 32,
    parameter int EVT_N = mmc_evt_pkg::EVT_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [EVT_N-1:0] mask_q
);
    logic unused_hi;
    assign unused_hi = ^wr_data[BUS_W-1:EVT_N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data[EVT_N-1:0];
        end
    end
endmodule

// File: rtl/mmc_evt_pend_reg.sv
module mmc_evt_pend_reg #(
    parameter int EVT_N      = mmc_evt_pkg::EVT_COUNT,
    parameter int CLKOFF_IDX = mmc_evt_pkg::EV_CLK_OFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] set_i,
    input  logic [EVT_N-1:0] clr_i,
    input  logic             clkoff_set,
    input  logic             clkoff_clr,
    output logic [EVT_N-1:0] pend_q
);
    for (genvar g = 0; g < EVT_N; g++) begin : g_bit
        if (g == CLKOFF_IDX) begin : g_clkoff
            // Clock control has the last word on this bit; stop beats start
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[g] <= 1'b0;
                end else if (clkoff_set) begin
                    pend_q[g] <= 1'b1;
                end else if (clkoff_clr) begin
                    pend_q[g] <= 1'b0;
                end else if (set_i[g]) begin
                    pend_q[g] <= 1'b1;
                end else if (clr_i[g]) begin
                    pend_q[g] <= 1'b0;
                end
            end
        end else begin : g_plain
            // Set wins over a coincident clear so no event is lost
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[g] <= 1'b0;
                end else if (set_i[g]) begin
                    pend_q[g] <= 1'b1;
                end else if (clr_i[g]) begin
                    pend_q[g] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mmc_evt_clk_fsm.sv
module mmc_evt_clk_fsm
    import mmc_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic             running,
    output logic             clkoff_set,
    output logic             clkoff_clr,
    output logic             abort_pulse
);
    clk_state_e state_q, state_d;
    clk_cmd_t   cmd;

    always_comb begin
        cmd.stop  = wr_en & wr_data[CTL_STOP_BIT];
        cmd.start = wr_en & wr_data[CTL_START_BIT];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLK_HALTED: begin
                if (!cmd.stop && cmd.start) begin
                    state_d = CLK_RUNNING;
                end
            end
            CLK_RUNNING: begin
                if (cmd.stop) begin
                    state_d = CLK_HALTED;
                end
            end
            default: state_d = CLK_HALTED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CLK_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
        end else begin
            abort_pulse <= cmd.stop;
        end
    end

    assign running    = (state_q == CLK_RUNNING);
    assign clkoff_set = cmd.stop;
    assign clkoff_clr = cmd.start & ~cmd.stop;
endmodule

// File: rtl/mmc_evt_route.sv
module mmc_evt_route #(
    parameter int EVT_N  = mmc_evt_pkg::EVT_COUNT,
    parameter int RX_IDX = mmc_evt_pkg::EV_RX_REQ,
    parameter int TX_IDX = mmc_evt_pkg::EV_TX_REQ
) (
    input  logic [EVT_N-1:0] pend,
    input  logic [EVT_N-1:0] mask,
    input  logic             dma_en,
    output logic             irq,
    output logic             rx_req,
    output logic             tx_req
);
    localparam logic [EVT_N-1:0] DMA_SEL =
        (EVT_N'(1) << RX_IDX) | (EVT_N'(1) << TX_IDX);

    logic [EVT_N-1:0] eff_mask;

    always_comb begin
        eff_mask = mask | (dma_en ? DMA_SEL : '0);
        irq      = |(pend & ~eff_mask);
        rx_req   = dma_en & pend[RX_IDX];
        tx_req   = dma_en & pend[TX_IDX];
    end
endmodule

// File: rtl/mmc_evt_router.sv
module mmc_evt_router
    import mmc_evt_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int EVT_N = EVT_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr_en,
    input  logic [BUS_W-1:0] mask_wr_data,
    output logic [EVT_N-1:0] mask_q,
    output logic [EVT_N-1:0] pend_q,
    input  logic [EVT_N-1:0] evt_set,
    input  logic [EVT_N-1:0] evt_clr,
    input  logic             dma_en,
    input  logic             clkctl_wr_en,
    input  logic [1:0]       clkctl_wr_data,
    output logic             irq,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             clk_running,
    output logic             xfer_abort
);
    logic clkoff_set;
    logic clkoff_clr;

    mmc_evt_mask_reg #(.BUS_W(BUS_W), .EVT_N(EVT_N)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr_en),
        .wr_data (mask_wr_data),
        .mask_q  (mask_q)
    );

    mmc_evt_clk_fsm u_clk (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (clkctl_wr_en),
        .wr_data     (clkctl_wr_data),
        .running     (clk_running),
        .clkoff_set  (clkoff_set),
        .clkoff_clr  (clkoff_clr),
        .abort_pulse (xfer_abort)
    );

    mmc_evt_pend_reg #(.EVT_N(EVT_N), .CLKOFF_IDX(EV_CLK_OFF)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (evt_set),
        .clr_i      (evt_clr),
        .clkoff_set (clkoff_set),
        .clkoff_clr (clkoff_clr),
        .pend_q     (pend_q)
    );

    mmc_evt_route #(.EVT_N(EVT_N), .RX_IDX(EV_RX_REQ), .TX_IDX(EV_TX_REQ)) u_route (
        .pend   (pend_q),
        .mask   (mask_q),
        .dma_en (dma_en),
        .irq    (irq),
        .rx_req (rx_dma_req),
        .tx_req (tx_dma_req)
    );
endmodule

// File: rtl/mmc_evt_router_chk.sv
module mmc_evt_router_chk #(
    parameter int BUS_W = 32,
    parameter int EVT_N = mmc_evt_pkg::EVT_COUNT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mask_wr_en,
    input logic [BUS_W-1:0] mask_wr_data,
    input logic [EVT_N-1:0] mask_q,
    input logic [EVT_N-1:0] pend_q,
    input logic [EVT_N-1:0] evt_set,
    input logic [EVT_N-1:0] evt_clr,
    input logic             dma_en,
    input logic             clkctl_wr_en,
    input logic [1:0]       clkctl_wr_data,
    input logic             irq,
    input logic             rx_dma_req,
    input logic             tx_dma_req,
    input logic             clk_running,
    input logic             xfer_abort
);
    localparam logic [EVT_N-1:0] CLKOFF_M = EVT_N'(1) << mmc_evt_pkg::EV_CLK_OFF;
    localparam logic [EVT_N-1:0] FIFO_M   = (EVT_N'(1) << mmc_evt_pkg::EV_RX_REQ) |
                                            (EVT_N'(1) << mmc_evt_pkg::EV_TX_REQ);

    p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> mask_q == $past(mask_wr_data[EVT_N-1:0]));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_q) & ~$past(evt_clr) & ~pend_q & ~CLKOFF_M) == '0));

    p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set & ~CLKOFF_M) != '0) |=>
            ((pend_q & $past(evt_set) & ~CLKOFF_M) == ($past(evt_set) & ~CLKOFF_M)));

    p_irq_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~mask_q & ~FIFO_M) != '0) |-> irq);

    p_fifo_diverted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && ((pend_q & ~mask_q & ~FIFO_M) == '0)) |-> !irq);

    p_dma_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> (!rx_dma_req && !tx_dma_req));

    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clkctl_wr_en && clkctl_wr_data == 2'b10) |=>
            (clk_running && !pend_q[mmc_evt_pkg::EV_CLK_OFF]));

    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clkctl_wr_en && clkctl_wr_data[0]) |=>
            (!clk_running && pend_q[mmc_evt_pkg::EV_CLK_OFF] && xfer_abort));

    p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> $past(clkctl_wr_en && clkctl_wr_data[0]));

    p_noop_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clkctl_wr_en && clkctl_wr_data == 2'b00 && !evt_set[mmc_evt_pkg::EV_CLK_OFF]
         && !evt_clr[mmc_evt_pkg::EV_CLK_OFF]) |=>
            ($stable(clk_running) && $stable(pend_q[mmc_evt_pkg::EV_CLK_OFF])));
endmodule

bind mmc_evt_router mmc_evt_router_chk #(.BUS_W(BUS_W), .EVT_N(EVT_N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mask_wr_en     (mask_wr_en),
    .mask_wr_data   (mask_wr_data),
    .mask_q         (mask_q),
    .pend_q         (pend_q),
    .evt_set        (evt_set),
    .evt_clr        (evt_clr),
    .dma_en         (dma_en),
    .clkctl_wr_en   (clkctl_wr_en),
    .clkctl_wr_data (clkctl_wr_data),
    .irq            (irq),
    .rx_dma_req     (rx_dma_req),
    .tx_dma_req     (tx_dma_req),
    .clk_running    (clk_running),
    .xfer_abort     (xfer_abort)
);

// File: tb/mmc_evt_router_tb.sv
module mmc_evt_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_wr_en = 1'b0;
    logic [31:0] mask_wr_data = '0;
    logic [12:0] mask_q;
    logic [12:0] pend_q;
    logic [12:0] evt_set = '0;
    logic [12:0] evt_clr = '0;
    logic        dma_en = 1'b0;
    logic        clkctl_wr_en = 1'b0;
    logic [1:0]  clkctl_wr_data = '0;
    logic        irq, rx_dma_req, tx_dma_req, clk_running, xfer_abort;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mmc_evt_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_q(mask_q),
        .pend_q(pend_q), .evt_set(evt_set), .evt_clr(evt_clr), .dma_en(dma_en),
        .clkctl_wr_en(clkctl_wr_en), .clkctl_wr_data(clkctl_wr_data),
        .irq(irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .clk_running(clk_running), .xfer_abort(xfer_abort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Each helper drives for one cycle and returns at the negedge after the update
    task automatic wr_mask(input logic [31:0] v);
        @(negedge clk); mask_wr_en = 1'b1; mask_wr_data = v;
        @(negedge clk); mask_wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [12:0] s, input logic [12:0] c);
        @(negedge clk); evt_set = s; evt_clr = c;
        @(negedge clk); evt_set = '0; evt_clr = '0;
    endtask

    task automatic wr_ctl(input logic [1:0] v);
        @(negedge clk); clkctl_wr_en = 1'b1; clkctl_wr_data = v;
        @(negedge clk); clkctl_wr_en = 1'b0; clkctl_wr_data = '0;
    endtask

    task automatic t_reset;
        chk("R1 pend", pend_q, 0);
        chk("R1 mask", mask_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx", rx_dma_req, 0);
        chk("R1 tx", tx_dma_req, 0);
        chk("R1 clk", clk_running, 0);
        chk("R1 abort", xfer_abort, 0);
    endtask

    task automatic t_mask;
        wr_mask(32'hFFFF_FFFF);
        chk("R2 width all-ones", mask_q, 32'h1FFF);
        wr_mask(32'h0000_A5A5);
        chk("R2 width pattern", mask_q, 32'h05A5);
        wr_mask(32'h0);
        strobe(13'h200, 13'h0);
        chk("R4 unmasked irq", irq, 1);
        wr_mask(32'h200);
        chk("R2 masked suppresses", irq, 0);
        wr_mask(32'h0);
        chk("R4 unmask restores", irq, 1);
        strobe(13'h0, 13'h200);
        chk("R4 cleared", irq, 0);
    endtask

    task automatic t_sticky;
        strobe(13'h0005, 13'h0);
        chk("R3 set", pend_q, 32'h5);
        repeat (3) @(negedge clk);
        chk("R3 sticky", pend_q, 32'h5);
        strobe(13'h0, 13'h0001);
        chk("R3 clear one", pend_q, 32'h4);
        strobe(13'h0004, 13'h0004);
        chk("R3 set wins", pend_q, 32'h4);
        strobe(13'h0, 13'h0004);
        chk("R3 clear all", pend_q, 32'h0);
    endtask

    task automatic t_dma;
        strobe(13'h0020, 13'h0);
        chk("R5 dma off irq", irq, 1);
        chk("R6 dma off rx low", rx_dma_req, 0);
        @(negedge clk); dma_en = 1'b1;
        @(negedge clk);
        chk("R5 rx diverted", irq, 0);
        chk("R6 rx follows", rx_dma_req, 1);
        chk("R6 tx idle", tx_dma_req, 0);
        strobe(13'h0040, 13'h0);
        chk("R6 tx follows", tx_dma_req, 1);
        chk("R5 tx diverted", irq, 0);
        strobe(13'h0001, 13'h0);
        chk("R5 other event irq", irq, 1);
        chk("R6 rx kept", rx_dma_req, 1);
        @(negedge clk); dma_en = 1'b0;
        @(negedge clk);
        chk("R6 both low off rx", rx_dma_req, 0);
        chk("R6 both low off tx", tx_dma_req, 0);
        strobe(13'h0, 13'h0061);
        chk("R6 cleanup", pend_q, 32'h0);
    endtask

    task automatic t_clock;
        strobe(13'h0010, 13'h0);
        chk("R3 clkoff set by engine", pend_q, 32'h10);
        wr_ctl(2'b10);
        chk("R7 running", clk_running, 1);
        chk("R7 clkoff cleared", pend_q, 32'h0);
        chk("R7 no abort", xfer_abort, 0);
        wr_ctl(2'b01);
        chk("R8 halted", clk_running, 0);
        chk("R8 clkoff set", pend_q, 32'h10);
        chk("R8 abort pulse", xfer_abort, 1);
        chk("R4 clkoff irq", irq, 1);
        @(negedge clk);
        chk("R8 abort one cycle", xfer_abort, 0);
        wr_ctl(2'b10);
        chk("R7 restart", clk_running, 1);
        wr_ctl(2'b11);
        chk("R9 both stop wins clk", clk_running, 0);
        chk("R9 both stop wins pend", pend_q, 32'h10);
        chk("R9 both abort", xfer_abort, 1);
        wr_ctl(2'b00);
        chk("R9 noop clk", clk_running, 0);
        chk("R9 noop pend", pend_q, 32'h10);
        chk("R9 noop abort", xfer_abort, 0);
        wr_ctl(2'b10);
        wr_ctl(2'b00);
        chk("R9 noop keeps running", clk_running, 1);
        chk("R9 noop keeps cleared", pend_q, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_sticky();
        t_dma();
        t_clock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule